// File: doc/BRIEF.md
# MAC Software Reset Sequencer

This block carries out an orderly software reset of an Ethernet MAC datapath. Software starts it by writing a command word with the reset bit set. The sequencer then quiets the datapath in a fixed order. It drops the receive enable and waits for the frame being received to end. It then drops the transmit enable and waits for the frame being sent to end. When the MAC is built with an internal receive FIFO, it waits for that FIFO to drain and pulses a flush. When statistics are enabled, it asks the counters to clear. It then ends by clearing the reset bit by itself.

Clearing the statistics needs the line clocks. If they are missing, the clear may never be acknowledged. A programmable cycle limit bounds that wait. When the limit expires, a sticky status flag is set and the sequence still completes. Command writes that arrive while the sequence runs are held back and take effect in the cycle the sequence ends. A synchronous hardware reset returns everything to its idle state at once.

Register map (word address on a 2-bit bus):
- Address 0: command.
- Address 1: status. Bit 0 is the timeout flag.
- Address 2: timeout limit.

Command bits:
- Bit 0: receive enable.
- Bit 1: transmit enable.
- Bit 2: software reset.
- Bit 3: statistics enable.

Top module: `mac_srst_seq`

## Requirements
- R1: A write of command (address 0) with bit 2 set while idle starts the sequence. Bit 2 reads 1 until the sequence ends and 0 afterwards. The readback then equals the written word with bit 2 cleared.
- R2: From the cycle after the start write, rx_enable is 0. tx_enable keeps its value from before the start until rx_in_frame has been seen low.
- R3: Each wait step advances on the clock edge at which its condition is seen. Once receive is quiet, tx_enable is 0 and the sequence stays in the transmit wait while tx_in_frame is high.
- R4: With HAS_FIFO set, the sequence waits for rx_fifo_empty after the transmit wait. It then raises rx_fifo_flush for exactly one cycle, once per sequence.
- R5: If bit 3 of the held command word is 1, stat_clear stays high until stat_clr_done is seen. The finish cycle follows. If bit 3 is 0, stat_clear never rises and the finish cycle follows the flush.
- R6: If stat_clr_done is still low when the wait counter reaches the limit register value, status bit 0 is set and the sequence finishes. The counter starts at 0 on the first wait cycle. An acknowledge in that same cycle wins over the timeout.
- R7: Status bit 0 is cleared by the write that starts the next sequence.
- R8: Command writes during a sequence do not change rx_enable or tx_enable, and their bit 2 does not restart the sequence. A command read shows the held word with bit 2 set. The held word becomes active in the cycle the sequence ends.
- R9: Hardware reset forces the idle state from the next edge, even mid-sequence. It clears the command word and the flag, and it loads the limit with DEF_LIMIT.
- R10: rx_fifo_flush and stat_clear are never high while the sequence is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Register write address |
| reg_wr_data | input | DW | Register write data |
| reg_rd_addr | input | 2 | Register read address |
| reg_rd_data | output | DW | Register read data (combinational) |
| rx_in_frame | input | 1 | Receive path is inside a frame |
| tx_in_frame | input | 1 | Transmit path is inside a frame |
| rx_fifo_empty | input | 1 | Internal receive FIFO is empty |
| stat_clr_done | input | 1 | Statistics counters report the clear as done |
| rx_enable | output | 1 | Receive enable to the datapath |
| tx_enable | output | 1 | Transmit enable to the datapath |
| rx_fifo_flush | output | 1 | One-cycle flush strobe to the receive FIFO |
| stat_clear | output | 1 | Clear request to the statistics counters |

## Verification
A wrong sequencer state appears within one cycle at the enables or strobes. Examples are a transmit enable dropped before receive is quiet, a flush repeated or missing, or a clear request abandoned early. It also appears as a reset bit that clears one or more cycles early or late against the wait conditions. A corrupt held command word or timeout flag appears in the first read after the sequence ends. Each sequence's length is therefore compared cycle by cycle with the length computed from the wait inputs.

// File: rtl/srst_pkg.sv
package srst_pkg;

    localparam int CMD_W  = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CMD    = 2'd0;
    localparam logic [ADDR_W-1:0] A_STATUS = 2'd1;
    localparam logic [ADDR_W-1:0] A_LIMIT  = 2'd2;

    // Command word; bit 0 is rx_en.
    typedef struct packed {
        logic [3:0] spare;
        logic       stat_en;
        logic       sw_rst;
        logic       tx_en;
        logic       rx_en;
    } cmd_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX_DRAIN,
        S_TX_DRAIN,
        S_FIFO_DRAIN,
        S_FLUSH,
        S_STAT_CLR,
        S_FINISH
    } seq_state_t;

    // Word held as configuration: the reset bit is never stored.
    function automatic cmd_t cmd_strip(cmd_t c);
        cmd_t r;
        r = c;
        r.sw_rst = 1'b0;
        return r;
    endfunction

    // Word presented on a read: reset bit reflects the running sequence.
    function automatic cmd_t cmd_readback(cmd_t c, logic busy);
        cmd_t r;
        r = c;
        r.sw_rst = busy;
        return r;
    endfunction

endpackage

// File: rtl/srst_regs.sv
module srst_regs
    import srst_pkg::*;
#(
    parameter int DW        = 16,
    parameter int TO_W      = 16,
    parameter int DEF_LIMIT = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    input  logic              busy,
    input  logic              finish,
    input  logic              to_set,
    output logic              start,
    output cmd_t              live_cmd,
    output cmd_t              held_cmd,
    output logic              to_flag,
    output logic [TO_W-1:0]   limit
);

    cmd_t            live_q, pend_q, wr_cmd;
    logic            to_q;
    logic [TO_W-1:0] limit_q;
    logic            cmd_wr;

    assign wr_cmd = cmd_t'(wr_data[CMD_W-1:0]);
    assign cmd_wr = wr_en && (wr_addr == A_CMD);
    assign start  = cmd_wr && wr_cmd.sw_rst && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q  <= '0;
            pend_q  <= '0;
            to_q    <= 1'b0;
            limit_q <= TO_W'(DEF_LIMIT);
        end else begin
            if (cmd_wr) begin
                if (busy || wr_cmd.sw_rst)
                    pend_q <= cmd_strip(wr_cmd);
                else
                    live_q <= wr_cmd;
            end
            if (finish)
                live_q <= cmd_wr ? cmd_strip(wr_cmd) : pend_q;
            if (start)
                to_q <= 1'b0;
            else if (to_set)
                to_q <= 1'b1;
            if (wr_en && (wr_addr == A_LIMIT))
                limit_q <= wr_data[TO_W-1:0];
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CMD:    rd_data[CMD_W-1:0] = cmd_readback(busy ? pend_q : live_q, busy);
            A_STATUS: rd_data[0]         = to_q;
            A_LIMIT:  rd_data[TO_W-1:0]  = limit_q;
            default:  rd_data            = '0;
        endcase
    end

    assign live_cmd = live_q;
    assign held_cmd = pend_q;
    assign to_flag  = to_q;
    assign limit    = limit_q;

endmodule

// File: rtl/srst_timer.sv
module srst_timer #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [TO_W-1:0] limit,
    output logic            expired
);

    logic [TO_W-1:0] cnt_q;

    assign expired = run && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else if (!expired)
            cnt_q <= cnt_q + TO_W'(1);
    end

endmodule

// File: rtl/srst_fsm.sv
module srst_fsm
    import srst_pkg::*;
#(
    parameter bit HAS_FIFO = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       rx_in_frame,
    input  logic       tx_in_frame,
    input  logic       rx_fifo_empty,
    input  logic       stat_clr_done,
    input  logic       stat_en,
    input  logic       expired,
    output seq_state_t state,
    output logic       busy,
    output logic       finish,
    output logic       to_set,
    output logic       timer_run
);

    seq_state_t state_q, nxt, after_tx, after_flush;

    assign after_flush = stat_en ? S_STAT_CLR : S_FINISH;

    generate
        if (HAS_FIFO) begin : g_fifo
            assign after_tx = S_FIFO_DRAIN;
        end else begin : g_no_fifo
            assign after_tx = after_flush;
        end
    endgenerate

    always_comb begin
        nxt = state_q;
        case (state_q)
            S_IDLE:       if (start)          nxt = S_RX_DRAIN;
            S_RX_DRAIN:   if (!rx_in_frame)   nxt = S_TX_DRAIN;
            S_TX_DRAIN:   if (!tx_in_frame)   nxt = after_tx;
            S_FIFO_DRAIN: if (rx_fifo_empty)  nxt = S_FLUSH;
            S_FLUSH:                          nxt = after_flush;
            S_STAT_CLR:   if (stat_clr_done || expired) nxt = S_FINISH;
            S_FINISH:                         nxt = S_IDLE;
            default:                          nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= nxt;
    end

    assign state     = state_q;
    assign busy      = (state_q != S_IDLE);
    assign finish    = (state_q == S_FINISH);
    assign timer_run = (state_q == S_STAT_CLR);
    assign to_set    = timer_run && expired && !stat_clr_done;

endmodule

// File: rtl/mac_srst_seq.sv
module mac_srst_seq
    import srst_pkg::*;
#(
    parameter int DW        = 16,
    parameter int TO_W      = 16,
    parameter int DEF_LIMIT = 1000,
    parameter bit HAS_FIFO  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_wr_addr,
    input  logic [DW-1:0]     reg_wr_data,
    input  logic [1:0]        reg_rd_addr,
    output logic [DW-1:0]     reg_rd_data,
    input  logic              rx_in_frame,
    input  logic              tx_in_frame,
    input  logic              rx_fifo_empty,
    input  logic              stat_clr_done,
    output logic              rx_enable,
    output logic              tx_enable,
    output logic              rx_fifo_flush,
    output logic              stat_clear
);

    seq_state_t      state;
    cmd_t            live_cmd, held_cmd;
    logic            seq_start, seq_busy, seq_finish, to_set, to_flag;
    logic            timer_run, tmr_expired;
    logic [TO_W-1:0] limit;

    srst_regs #(.DW(DW), .TO_W(TO_W), .DEF_LIMIT(DEF_LIMIT)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr_en),
        .wr_addr  (reg_wr_addr),
        .wr_data  (reg_wr_data),
        .rd_addr  (reg_rd_addr),
        .rd_data  (reg_rd_data),
        .busy     (seq_busy),
        .finish   (seq_finish),
        .to_set   (to_set),
        .start    (seq_start),
        .live_cmd (live_cmd),
        .held_cmd (held_cmd),
        .to_flag  (to_flag),
        .limit    (limit)
    );

    srst_fsm #(.HAS_FIFO(HAS_FIFO)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .start         (seq_start),
        .rx_in_frame   (rx_in_frame),
        .tx_in_frame   (tx_in_frame),
        .rx_fifo_empty (rx_fifo_empty),
        .stat_clr_done (stat_clr_done),
        .stat_en       (held_cmd.stat_en),
        .expired       (tmr_expired),
        .state         (state),
        .busy          (seq_busy),
        .finish        (seq_finish),
        .to_set        (to_set),
        .timer_run     (timer_run)
    );

    srst_timer #(.TO_W(TO_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (timer_run),
        .limit   (limit),
        .expired (tmr_expired)
    );

    assign rx_enable     = live_cmd.rx_en && (state == S_IDLE);
    assign tx_enable     = live_cmd.tx_en && ((state == S_IDLE) || (state == S_RX_DRAIN));
    assign rx_fifo_flush = (state == S_FLUSH);
    assign stat_clear    = (state == S_STAT_CLR);

endmodule

// File: rtl/srst_chk.sv
module srst_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       busy,
    input logic       finish,
    input logic       expired,
    input logic       to_flag,
    input logic [7:0] live_cmd,
    input logic       rx_enable,
    input logic       tx_enable,
    input logic       rx_fifo_flush,
    input logic       stat_clear,
    input logic       stat_clr_done
);

    p_start_busy_r1: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    p_rx_off_r2: assert property (@(posedge clk) disable iff (rst)
        busy |-> !rx_enable);

    p_tx_after_rx_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_enable) |-> !rx_enable);

    p_flush_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        rx_fifo_flush |=> !rx_fifo_flush);

    p_clr_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (stat_clear && !stat_clr_done && !expired) |=> stat_clear);

    p_flag_in_seq_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(to_flag) |-> busy);

    p_start_clears_r7: assert property (@(posedge clk) disable iff (rst)
        start |=> !to_flag);

    p_cfg_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !finish) |=> $stable(live_cmd));

    p_strobes_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!rx_fifo_flush && !stat_clear));

endmodule

bind mac_srst_seq srst_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .start         (seq_start),
    .busy          (seq_busy),
    .finish        (seq_finish),
    .expired       (tmr_expired),
    .to_flag       (to_flag),
    .live_cmd      (live_cmd),
    .rx_enable     (rx_enable),
    .tx_enable     (tx_enable),
    .rx_fifo_flush (rx_fifo_flush),
    .stat_clear    (stat_clear),
    .stat_clr_done (stat_clr_done)
);

// File: tb/tb_mac_srst_seq.sv
module tb_mac_srst_seq;

    localparam int DW  = 16;
    localparam int DEF = 1000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [1:0]    rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          rx_in = 1'b0, tx_in = 1'b0, f_empty = 1'b0, clr_done = 1'b0;
    logic          rx_en_o, tx_en_o, flush_o, clr_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    mac_srst_seq #(.DW(DW), .TO_W(16), .DEF_LIMIT(DEF), .HAS_FIFO(1'b1)) dut (
        .clk(clk), .rst(rst),
        .reg_wr_en(wr_en), .reg_wr_addr(wr_addr), .reg_wr_data(wr_data),
        .reg_rd_addr(rd_addr), .reg_rd_data(rd_data),
        .rx_in_frame(rx_in), .tx_in_frame(tx_in),
        .rx_fifo_empty(f_empty), .stat_clr_done(clr_done),
        .rx_enable(rx_en_o), .tx_enable(tx_en_o),
        .rx_fifo_flush(flush_o), .stat_clear(clr_o)
    );

    // rh/th: frame-active cycles; fh: cycle FIFO goes empty; sd: cycle clear ack
    typedef struct packed {
        logic [7:0] rh, th, fh, sd, lim, idle;
        logic       st, to;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{8'd0, 8'd0, 8'd0, 8'd0,   8'd8,  8'd6,  1'b1, 1'b0},
        '{8'd3, 8'd5, 8'd7, 8'd10,  8'd20, 8'd12, 1'b1, 1'b0},
        '{8'd2, 8'd1, 8'd0, 8'd0,   8'd8,  8'd7,  1'b0, 1'b0},
        '{8'd0, 8'd0, 8'd0, 8'd50,  8'd5,  8'd11, 1'b1, 1'b1},
        '{8'd4, 8'd0, 8'd9, 8'd0,   8'd0,  8'd13, 1'b1, 1'b0},
        '{8'd0, 8'd0, 8'd0, 8'd100, 8'd0,  8'd6,  1'b1, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        logic [DW-1:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9: reset state
        rd(2'd0, d); chk("R9 cmd after reset", d, 0);
        rd(2'd1, d); chk("R9 status after reset", d, 0);
        rd(2'd2, d); chk("R9 limit after reset", d, DEF);
        chk("R9 enables after reset", {rx_en_o, tx_en_o}, 0);
        chk("R10 strobes after reset", {flush_o, clr_o}, 0);

        wr(2'd0, 16'h0003);
        chk("R1 idle write applied", {rx_en_o, tx_en_o}, 2'b11);

        for (int v = 0; v < 6; v++) begin
            vec_t t;
            int idle_k, rxbad, txbad, flushes, clrs;
            logic [DW-1:0] cmd;
            t = VEC[v];
            cmd = 16'h0007 | (t.st ? 16'h0008 : 16'h0000);
            wr(2'd2, {8'd0, t.lim});
            rx_in = 1'b1; tx_in = 1'b1; f_empty = 1'b0; clr_done = 1'b0;
            wr(2'd0, cmd);
            idle_k = -1; rxbad = 0; txbad = 0; flushes = 0; clrs = 0;
            for (int k = 0; k < 250; k++) begin
                rd(2'd0, d);
                if (d[2] == 1'b0) begin
                    idle_k = k;
                    break;
                end
                if (k == 0) begin
                    rd(2'd1, d);
                    chk($sformatf("R7 flag cleared at start v%0d", v), d[0], 0);
                end
                if (k < int'(t.rh) + 1) begin
                    if (rx_en_o || !tx_en_o) rxbad++;
                end else if (rx_en_o || tx_en_o) txbad++;
                if (flush_o) flushes++;
                if (clr_o) clrs++;
                rx_in    = (k < int'(t.rh));
                tx_in    = (k < int'(t.th));
                f_empty  = (k >= int'(t.fh));
                clr_done = (k >= int'(t.sd));
                @(negedge clk);
            end
            chk($sformatf("R1 R3 R6 sequence length v%0d", v), idle_k, t.idle);
            chk($sformatf("R2 rx off, tx kept v%0d", v), rxbad, 0);
            chk($sformatf("R3 tx off after rx quiet v%0d", v), txbad, 0);
            chk($sformatf("R4 one flush v%0d", v), flushes, 1);
            chk($sformatf("R5 clear request v%0d", v), (clrs != 0), t.st);
            rd(2'd1, d);
            chk($sformatf("R6 timeout flag v%0d", v), d[0], t.to);
            rd(2'd0, d);
            chk($sformatf("R1 cmd readback v%0d", v), d, cmd & 16'hFFFB);
            chk($sformatf("R8 held cmd active v%0d", v), {rx_en_o, tx_en_o}, 2'b11);
            chk($sformatf("R10 strobes idle v%0d", v), {flush_o, clr_o}, 0);
            rx_in = 1'b0; tx_in = 1'b0;
            @(negedge clk);
        end

        // R8: writes during the sequence are held
        begin
            int clrs, n;
            rx_in = 1'b1; tx_in = 1'b0; f_empty = 1'b1; clr_done = 1'b0;
            wr(2'd0, 16'h0007);
            wr(2'd0, 16'h0005);
            chk("R8 tx held during rx drain", {rx_en_o, tx_en_o}, 2'b01);
            rd(2'd0, d);
            chk("R8 held word readback", d, 16'h0005);
            rx_in = 1'b0;
            clrs = 0; n = 0;
            d = 16'h0004;
            while (d[2] && n < 40) begin
                if (clr_o) clrs++;
                @(negedge clk);
                n++;
                rd(2'd0, d);
            end
            chk("R8 applied at end", {rx_en_o, tx_en_o}, 2'b10);
            chk("R8 cmd after end", d, 16'h0001);
            chk("R5 no clear when disabled", clrs, 0);
        end

        // R9: hardware reset mid-sequence
        wr(2'd2, 16'd3);
        rx_in = 1'b1;
        wr(2'd0, 16'h000F);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd(2'd0, d); chk("R9 cmd after mid reset", d, 0);
        rd(2'd2, d); chk("R9 limit after mid reset", d, DEF);
        rd(2'd1, d); chk("R9 flag after mid reset", d, 0);
        chk("R9 outputs after mid reset", {rx_en_o, tx_en_o, flush_o, clr_o}, 0);

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
            $finish;
        end
    end

endmodule